// File: doc/BRIEF.md
# Predicated Segment Load Address Generator

This block expands one predicated vector load into a stream of per-register load requests. A launch captures a base address, the addressing mode, the segment length, the vector length and the predicate controls. The block then emits one request per cycle. Each request carries a memory address, the destination register number and the element index that the returned data belongs to. A downstream load unit consumes the requests through a valid/ready pair. The load unit handles the memory access, alignment and element packing.

There are three ways to form the per-element offset. With unit stride, the step between consecutive accesses is the element size. With constant stride, the step is a scalar operand. When the offset operand is marked as a vector, the block reads the offset for each element through a small index read port, and that value replaces the computed offset. Within each element, a segment of `seg_len+1` accesses fills consecutive destination registers, moving forward by one step each time. A predicate mask, which can be inverted, selects which elements take part. Elements that are masked off produce no requests at all; the block does not zero them.

Top module: `seg_load_agen`

## Requirements
- R1: After reset, `req_valid` and `done` are low, and they stay low until `start` is asserted.
- R2: When `strided`=0 and `idx_vec`=0, the request for element i and segment slot j has address `base + i*(seg_len+1)*elem_bytes + j*elem_bytes`.
- R3: When `strided`=1, `stride_val` replaces `elem_bytes` in both the element offset and the segment step.
- R4: When `idx_vec`=1, `idx_rd_elem` shows the element currently being issued. The element offset is then the value on `idx_rd_data`, and the segment step still follows `strided`.
- R5: Each enabled element produces exactly `seg_len+1` requests, with `req_reg` = `dest_reg+j` taken modulo 2^REG_W and `req_elem` = i.
- R6: When `pred_en`=1, element i is issued only if `pred_mask[i] XOR pred_inv` is 1.
- R7: When `pred_en`=0, every element from 0 to `vec_len-1` is issued. Elements at or above `vec_len` are never issued, whatever the mask holds.
- R8: Requests come out in order: j rises fastest, then i rises. One request is accepted per cycle while `req_ready` is high. While `req_ready` is low, the pending request holds steady.
- R9: Address arithmetic wraps modulo 2^32, and no error is flagged.
- R10: `done` is high for one cycle, in the cycle after the final request is accepted. If a launch enables no element, `done` is high in the cycle after the `start` edge.
- R11: A `start` that arrives while requests are still outstanding is ignored, and so are operand changes made at that time. The current stream completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a new load; taken only when idle |
| base_addr | input | 32 | Scalar base address |
| elem_bytes | input | 32 | Element size in bytes (unit-stride step) |
| stride_val | input | 32 | Constant stride operand |
| strided | input | 1 | 1 selects constant stride, 0 selects unit stride |
| idx_vec | input | 1 | Offset operand is vectorised: use indexed offsets |
| seg_len | input | SEG_W | Segment length minus one |
| vec_len | input | IW+1 | Vector length, 0..VL_MAX |
| pred_mask | input | VL_MAX | Per-element predicate bits |
| pred_en | input | 1 | Predication enabled for the destination |
| pred_inv | input | 1 | Invert the predicate bits |
| dest_reg | input | REG_W | First destination register |
| idx_rd_elem | output | IW | Element index for the index-vector read |
| idx_rd_data | input | 32 | Index value for `idx_rd_elem` (combinational return) |
| req_valid | output | 1 | Request available |
| req_ready | input | 1 | Request accepted on this edge when valid |
| req_addr | output | 32 | Load address |
| req_reg | output | REG_W | Destination register |
| req_elem | output | IW | Destination element position |
| done | output | 1 | One-cycle pulse at the end of a load |

## Verification
The hardest cases to reach are a `start` that arrives in the middle of a stream and a backpressure stall in the middle of a segment. In both, the live state must survive input changes that the ports freely allow. The bench holds `req_ready` low on a fixed pattern while a segment is half issued. During that stall it also asserts `start` again, with a different base and mode on the operand inputs, and then checks every remaining request against the sequence computed from the first launch. Sparse, inverted and empty predicates are mixed with out-of-range mask bits, so that skipped elements and an empty launch both reach `done` on the expected cycle.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int unsigned ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;

  // offset of element elem: an index value, or elem*(seg+1)*step
  function automatic addr_t elem_offset(input logic indexed, input addr_t idx_val,
                                        input addr_t elem, input addr_t seg,
                                        input addr_t step);
    addr_t o;
    if (indexed) o = idx_val;
    else         o = elem * (seg + addr_t'(1)) * step;
    return o;
  endfunction

  // address of segment slot j inside one element
  function automatic addr_t slot_addr(input addr_t base, input addr_t off,
                                      input addr_t j, input addr_t step);
    return base + off + j * step;
  endfunction
endpackage

// File: rtl/agen_elem_pick.sv
module agen_elem_pick #(
  parameter int VL_MAX = 16,
  localparam int IW = $clog2(VL_MAX)
) (
  input  logic [VL_MAX-1:0] pending,
  output logic              any,
  output logic [VL_MAX-1:0] pick_1h,
  output logic [IW-1:0]     pick_idx
);
  logic [VL_MAX:0] below;   // below[k]: some pending bit under k

  assign below[0] = 1'b0;
  genvar k;
  generate
    for (k = 0; k < VL_MAX; k++) begin : g_scan
      assign pick_1h[k]  = pending[k] & ~below[k];
      assign below[k+1]  = below[k] | pending[k];
    end
  endgenerate

  assign any = below[VL_MAX];

  always_comb begin
    pick_idx = '0;
    for (int n = 0; n < VL_MAX; n++)
      if (pick_1h[n]) pick_idx = pick_idx | IW'(n);
  end

  // R6/R8: exactly one element is selected whenever any is pending
  always_comb begin
    a_r8_single_pick: assert ($onehot0(pick_1h) && (any == (pick_1h != '0)));
  end
endmodule

// File: rtl/agen_addr_calc.sv
module agen_addr_calc
  import agen_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int IW    = 4
) (
  input  addr_t            base,
  input  addr_t            step,
  input  logic             indexed,
  input  addr_t            idx_val,
  input  logic [IW-1:0]    elem,
  input  logic [SEG_W-1:0] seg,
  input  logic [SEG_W-1:0] slot,
  output addr_t            addr
);
  addr_t off;
  assign off  = elem_offset(indexed, idx_val, addr_t'(elem), addr_t'(seg), step);
  assign addr = slot_addr(base, off, addr_t'(slot), step);
endmodule

// File: rtl/seg_load_agen.sv
module seg_load_agen
  import agen_pkg::*;
#(
  parameter int VL_MAX = 16,
  parameter int SEG_W  = 3,
  parameter int REG_W  = 5,
  localparam int IW    = $clog2(VL_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] elem_bytes,
  input  logic [ADDR_W-1:0] stride_val,
  input  logic              strided,
  input  logic              idx_vec,
  input  logic [SEG_W-1:0]  seg_len,
  input  logic [IW:0]       vec_len,
  input  logic [VL_MAX-1:0] pred_mask,
  input  logic              pred_en,
  input  logic              pred_inv,
  input  logic [REG_W-1:0]  dest_reg,
  output logic [IW-1:0]     idx_rd_elem,
  input  logic [ADDR_W-1:0] idx_rd_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [REG_W-1:0]  req_reg,
  output logic [IW-1:0]     req_elem,
  output logic              done
);
  // latched operands and progress
  logic [VL_MAX-1:0] pending_q;
  logic [SEG_W-1:0]  slot_q, seg_q;
  addr_t             base_q, step_q;
  logic              idx_q;
  logic [REG_W-1:0]  rd_q;
  logic [IW:0]       vl_q;
  logic              done_q;

  // named events
  logic              busy, launch, accept, last_slot, final_accept;
  logic [VL_MAX-1:0] launch_mask, pick_1h, pending_after;
  logic [IW-1:0]     cur_elem;

  genvar k;
  generate
    for (k = 0; k < VL_MAX; k++) begin : g_mask
      assign launch_mask[k] = (IW+1)'(k) < vec_len &&
                              (!pred_en || (pred_mask[k] ^ pred_inv));
    end
  endgenerate

  agen_elem_pick #(.VL_MAX(VL_MAX)) u_pick (
    .pending (pending_q),
    .any     (busy),
    .pick_1h (pick_1h),
    .pick_idx(cur_elem)
  );

  agen_addr_calc #(.SEG_W(SEG_W), .IW(IW)) u_addr (
    .base   (base_q),
    .step   (step_q),
    .indexed(idx_q),
    .idx_val(idx_rd_data),
    .elem   (cur_elem),
    .seg    (seg_q),
    .slot   (slot_q),
    .addr   (req_addr)
  );

  assign launch        = start & ~busy;
  assign accept        = busy & req_ready;
  assign last_slot     = slot_q == seg_q;
  assign pending_after = pending_q & ~pick_1h;
  assign final_accept  = accept & last_slot & (pending_after == '0);

  assign req_valid   = busy;
  assign req_elem    = cur_elem;
  assign idx_rd_elem = cur_elem;
  assign req_reg     = rd_q + REG_W'(slot_q);
  assign done        = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
      slot_q    <= '0;
      seg_q     <= '0;
      base_q    <= '0;
      step_q    <= '0;
      idx_q     <= 1'b0;
      rd_q      <= '0;
      vl_q      <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        pending_q <= launch_mask;
        slot_q    <= '0;
        seg_q     <= seg_len;
        base_q    <= base_addr;
        step_q    <= strided ? stride_val : elem_bytes;
        idx_q     <= idx_vec;
        rd_q      <= dest_reg;
        vl_q      <= vec_len;
        done_q    <= (launch_mask == '0);
      end else if (accept) begin
        if (last_slot) begin
          pending_q <= pending_after;
          slot_q    <= '0;
          done_q    <= final_accept;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  // R8: a stalled request holds steady
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_elem) && $stable(req_reg)
                                && $stable(req_addr));
  // R8: slots inside a segment stay on one element
  a_r8_elem_within_seg: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !last_slot |=> req_valid && req_elem == $past(req_elem));
  // R5: slot counter never passes the segment length
  a_r5_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> slot_q <= seg_q);
  // R7: no element at or above the vector length is issued
  a_r7_elem_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> {1'b0, req_elem} < vl_q);
  // R10: done only when the stream has drained
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);
  // R11: a start while busy leaves the stream running
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !final_accept |=> req_valid && !done);
endmodule

// File: tb/seg_load_agen_test.sv
`timescale 1ns/1ps
module seg_load_agen_test;
  localparam int VLM = 16;
  localparam int IW  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0, elem_bytes = '0, stride_val = '0;
  logic        strided = 1'b0, idx_vec = 1'b0;
  logic [2:0]  seg_len = '0;
  logic [IW:0] vec_len = '0;
  logic [VLM-1:0] pred_mask = '0;
  logic        pred_en = 1'b0, pred_inv = 1'b0;
  logic [4:0]  dest_reg = '0;
  logic [IW-1:0] idx_rd_elem;
  logic [31:0] idx_rd_data;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [4:0]  req_reg;
  logic [IW-1:0] req_elem;
  logic        done;

  logic [31:0] idx_tab [VLM];
  assign idx_rd_data = idx_tab[idx_rd_elem];

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  seg_load_agen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .elem_bytes(elem_bytes), .stride_val(stride_val), .strided(strided),
    .idx_vec(idx_vec), .seg_len(seg_len), .vec_len(vec_len),
    .pred_mask(pred_mask), .pred_en(pred_en), .pred_inv(pred_inv),
    .dest_reg(dest_reg), .idx_rd_elem(idx_rd_elem), .idx_rd_data(idx_rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_reg(req_reg), .req_elem(req_elem), .done(done)
  );

  task automatic check(input string req, input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one load: expected stream computed here from the requirement text
  task automatic run_case(input string req, input logic [31:0] b, input logic [31:0] esz,
                          input logic [31:0] stv, input bit strd, input bit idxv,
                          input int seg, input int vl, input logic [VLM-1:0] m,
                          input bit pe, input bit inv, input int rd,
                          input bit stall, input bit poke);
    logic [31:0] ea [128];
    int          er [128];
    int          ee [128];
    int          n = 0;
    int          got = 0;
    bit          fin = 0;
    logic [31:0] step = strd ? stv : esz;
    for (int i = 0; i < vl; i++) begin
      bit en = pe ? (m[i] ^ inv) : 1'b1;
      if (en) begin
        for (int j = 0; j <= seg; j++) begin
          logic [31:0] off = idxv ? idx_tab[i] : 32'(i) * 32'(seg + 1) * step;
          ea[n] = b + off + 32'(j) * step;
          er[n] = (rd + j) % 32;
          ee[n] = i;
          n++;
        end
      end
    end
    @(negedge clk);
    base_addr = b; elem_bytes = esz; stride_val = stv; strided = strd;
    idx_vec = idxv; seg_len = 3'(seg); vec_len = 5'(vl); pred_mask = m;
    pred_en = pe; pred_inv = inv; dest_reg = 5'(rd); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (got == n) begin
        check(req, done && !req_valid, "done after final accept (R10)",
              {62'b0, done, req_valid}, 64'h2);
        fin = 1;
        break;
      end
      if (done) check(req, 1'b0, "early done (R10)", 64'(got), 64'(n));
      if (poke && cyc == 2) begin
        start = 1'b1; base_addr = 32'hDEAD_0000; strided = ~strd; seg_len = 3'd0;
      end else begin
        start = 1'b0;
      end
      req_ready = stall ? (cyc % 3 != 1) : 1'b1;
      if (req_valid && req_ready) begin
        check(req, req_addr == ea[got] && int'(req_reg) == er[got] &&
                   int'(req_elem) == ee[got] && idx_rd_elem == req_elem,
              $sformatf("request %0d addr/reg/elem", got),
              {req_addr, 11'b0, req_reg, 12'b0, req_elem},
              {ea[got], 11'b0, 5'(er[got]), 12'b0, 4'(ee[got])});
        got++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    req_ready = 1'b0;
    if (!fin) check(req, 1'b0, "stream did not finish", 64'(got), 64'(n));
  endtask

  task automatic t_reset;
    check("R1", !req_valid && !done, "idle after reset", {62'b0, req_valid, done}, 64'h0);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < VLM; i++) idx_tab[i] = 32'h100 * 32'(i * 7 % 5) + 32'(i * 3);
    repeat (3) @(negedge clk);
    t_reset();
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R2 unit stride, R7 no predication
    run_case("R2", 32'h1000, 32'd4, 32'd0, 0, 0, 0, 5, 16'h0, 0, 0, 3, 0, 0);
    // R3 constant stride with R5 segments and R6 sparse predicate
    run_case("R3", 32'h2000, 32'd4, 32'h40, 1, 0, 2, 4, 16'b1010, 1, 0, 8, 0, 0);
    // R6 inverted predicate under R8 backpressure
    run_case("R6", 32'h3000, 32'd2, 32'd0, 0, 0, 1, 6, 16'b000101, 1, 1, 1, 1, 0);
    // R4 indexed offsets
    run_case("R4", 32'h4000, 32'd8, 32'd0, 0, 1, 1, 4, 16'h0, 0, 0, 10, 0, 0);
    run_case("R4", 32'h5000, 32'd8, 32'h20, 1, 1, 2, 7, 16'h5A, 1, 0, 12, 1, 0);
    // R9 address wrap
    run_case("R9", 32'hFFFF_FFF0, 32'd4, 32'h10, 1, 0, 1, 3, 16'h0, 0, 0, 0, 0, 0);
    // R10 empty predicate and zero length
    run_case("R10", 32'h6000, 32'd4, 32'd0, 0, 0, 3, 8, 16'h0, 1, 0, 0, 0, 0);
    run_case("R10", 32'h6000, 32'd4, 32'd0, 0, 0, 3, 0, 16'hFFFF, 0, 0, 0, 0, 0);
    // R11 start and operand changes while busy
    run_case("R11", 32'h7000, 32'd4, 32'd0, 0, 0, 2, 4, 16'h0, 0, 0, 4, 1, 1);
    // R5 full length, longest segment, register wrap
    run_case("R5", 32'h8000, 32'd1, 32'd0, 0, 0, 7, 16, 16'h0, 0, 0, 30, 0, 0);
    // R7 mask bits above the vector length have no effect
    run_case("R7", 32'h9000, 32'd4, 32'd0, 0, 0, 0, 3, 16'hFFFF, 1, 0, 2, 0, 0);
    run_case("R8", 32'hA000, 32'd4, 32'h0C, 1, 0, 3, 5, 16'h0, 0, 0, 6, 1, 0);
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule